// File: doc/BRIEF.md
# Programmable Serial Frame Clock Generator

This block produces the shared bit clock and frame sync for a synchronous serial audio or data link. It runs on a fast system clock and receives three master clocks as one-cycle clock-enable pulses: a lower-rate internal master, a higher-rate internal master and an external master. One of them is selected as the active master. Its pulses are divided by a programmable even ratio n = 4·k, where k is a 3-bit code from 1 to 6, so n ranges from 4 to 24. This gives the bit clock. The bit clock is then divided by 128 to mark sample frames.

The outputs are meant for the data shifters that sit next to the block. The block provides the bit-clock level and one-cycle strobes for each rising and falling edge. It also provides a 7-bit bit index within the frame, a one-cycle frame-start strobe, and a sync level that is high for the first 16 bit periods of every frame.

A configuration is offered with a load strobe and checked when it arrives:
- A legal configuration is held as pending and takes effect only at the next frame boundary. No bit period is ever cut short.
- An illegal configuration is refused. The block keeps its previous setting and raises an error flag.
- When the link is bound to the codec, the higher-rate internal master is not allowed.

Top module: `serial_frame_clkgen`

## Requirements
- R1: After reset the bit clock is low, both edge strobes, the frame-start strobe, the sync level and the error flag are 0, and the bit index is 127. The active setting is source 0 with code 1 (n = 4).
- R2: Source codes are: 0 = lower-rate internal master, 1 = higher-rate internal master, 2 = external master. Only pulses on the active source's input bit (same index as the source code) advance the divider. Source code 3 is illegal and is refused.
- R3: With active code k, the bit clock stays high for exactly 2·k active master pulses and low for exactly 2·k active master pulses. The pulse that completes a half period flips the level on the following system clock edge.
- R4: `bclk_rise_o` and `bclk_fall_o` are each high for exactly one system cycle, in the same cycle in which `bclk_o` shows the new level. They are never high together.
- R5: The bit index increases by one on every rising bit-clock edge, wraps from 127 to 0, and changes at no other time.
- R6: `frame_start_o` is high for one cycle, together with the rising strobe whose bit index becomes 0.
- R7: `sync_o` is high while the bit index is 0 to 15 and low while it is 16 to 127.
- R8: A load with code 0 or 7 is refused. The active and pending settings are unchanged, and `cfg_err_o` is 1 from the next cycle.
- R9: A load with `cfg_codec_i` = 1 and source code 1 is refused in the same way as in R8.
- R10: An accepted load changes no bit period of the current frame. The new source and code govern the divider from the rising edge that starts bit 0 of the next frame.
- R11: An accepted load clears `cfg_err_o` from the next cycle. The flag otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_tick_i | input | 3 | One-cycle master clock pulses, bit i belongs to source code i |
| cfg_load_i | input | 1 | Offer a new configuration this cycle |
| cfg_src_i | input | 2 | Requested master source code |
| cfg_code_i | input | 3 | Requested divide code k, n = 4·k |
| cfg_codec_i | input | 1 | Link is bound to the codec (restricts sources) |
| bclk_o | output | 1 | Bit clock level |
| bclk_rise_o | output | 1 | One-cycle strobe at a rising bit-clock edge |
| bclk_fall_o | output | 1 | One-cycle strobe at a falling bit-clock edge |
| bit_idx_o | output | 7 | Bit index within the frame, 0 to 127 |
| frame_start_o | output | 1 | One-cycle strobe at the start of bit 0 |
| sync_o | output | 1 | Frame sync level, high for bits 0 to 15 |
| cfg_err_o | output | 1 | Last offered configuration was refused |

## Verification
The bench loads a new configuration in the middle of a frame and measures the first high phase after the next frame start. A design that applied settings at once would show a half period of the new length before the boundary. A design that never applied them would keep the old length after it.

Once the external master is active, the bench drives pulses only on the two internal inputs and expects the outputs to stay frozen. A wrong multiplexer would keep the bit clock running.

The bench offers code 0, code 7, source 3, and the higher-rate internal source with the codec bound. A validator that let any of these through would clear the error flag, and would either give a divide of zero or lock up on a missing source. The cycle-by-cycle comparison also covers the wrap from 127 to 0 and the rise of sync exactly at frame start. A design that got these wrong would skip a bit or shift the sync window.

// File: rtl/sfcg_pkg.sv
package sfcg_pkg;

   typedef enum logic [1:0] {
      SRC_INT_LO = 2'd0,
      SRC_INT_HI = 2'd1,
      SRC_EXT    = 2'd2,
      SRC_NONE   = 2'd3
   } sfcg_src_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sfcg_cfg.sv
module sfcg_cfg #(
   parameter int NUM_SRC      = 3,
   parameter int SRC_W        = 2,
   parameter int CODE_W       = 3,
   parameter int CODE_MIN     = 1,
   parameter int CODE_MAX     = 6,
   parameter int RESTRICT_SRC = 1,
   parameter int DEF_SRC      = 0,
   parameter int DEF_CODE     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [SRC_W-1:0]  src_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              codec_i,
   input  logic              apply_i,
   output logic [SRC_W-1:0]  act_src_o,
   output logic [CODE_W-1:0] act_code_o,
   output logic              err_o
);

   if (CODE_MIN < 1 || CODE_MAX < CODE_MIN || CODE_MAX >= (1 << CODE_W)) begin : g_bad_code
      $error("sfcg_cfg: code range does not fit CODE_W");
   end
   if (DEF_CODE < CODE_MIN || DEF_CODE > CODE_MAX || DEF_SRC >= NUM_SRC) begin : g_bad_def
      $error("sfcg_cfg: default setting is not legal");
   end

   logic              src_ok;
   logic              code_ok;
   logic              restrict_hit;
   logic              legal;
   logic [SRC_W-1:0]  pend_src_q;
   logic [CODE_W-1:0] pend_code_q;

   if (NUM_SRC == (1 << SRC_W)) begin : g_src_full
      assign src_ok = 1'b1;
   end else begin : g_src_part
      assign src_ok = (src_i < SRC_W'(NUM_SRC));
   end

   assign code_ok      = (code_i >= CODE_W'(CODE_MIN)) && (code_i <= CODE_W'(CODE_MAX));
   assign restrict_hit = codec_i && (src_i == SRC_W'(RESTRICT_SRC));
   assign legal        = src_ok && code_ok && !restrict_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_src_q  <= SRC_W'(DEF_SRC);
         pend_code_q <= CODE_W'(DEF_CODE);
         act_src_o   <= SRC_W'(DEF_SRC);
         act_code_o  <= CODE_W'(DEF_CODE);
         err_o       <= 1'b0;
      end else begin
         if (apply_i) begin
            act_src_o  <= pend_src_q;
            act_code_o <= pend_code_q;
         end
         if (load_i) begin
            if (legal) begin
               pend_src_q  <= src_i;
               pend_code_q <= code_i;
               err_o       <= 1'b0;
            end else begin
               err_o <= 1'b1;
            end
         end
      end
   end

   assert_defer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> ($stable(act_src_o) && $stable(act_code_o)));
   assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !code_ok) |=> err_o);
   assert_codec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && codec_i && src_i == SRC_W'(RESTRICT_SRC)) |=> err_o);
   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(err_o));
   assert_act_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code_o >= CODE_W'(CODE_MIN)) && (act_code_o <= CODE_W'(CODE_MAX)));

endmodule

// File: rtl/sfcg_tick_sel.sv
module sfcg_tick_sel #(
   parameter int NUM_SRC = 3,
   parameter int SRC_W   = 2
) (
   input  logic [NUM_SRC-1:0] ticks_i,
   input  logic [SRC_W-1:0]   sel_i,
   output logic               tick_o
);

   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = ticks_i[i] && (sel_i == SRC_W'(i));
   end

   assign tick_o = |hit;

endmodule

// File: rtl/sfcg_divider.sv
module sfcg_divider #(
   parameter int CODE_W   = 3,
   parameter int CODE_MAX = 6,
   parameter int STEP     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              rise_evt_o,
   output logic              bclk_o,
   output logic              rise_o,
   output logic              fall_o
);

   if (STEP < 2 || (STEP % 2) != 0) begin : g_bad_step
      $error("sfcg_divider: STEP must be even and at least 2");
   end

   localparam int HALF_UNIT = STEP / 2;
   localparam int HALF_MAX  = HALF_UNIT * CODE_MAX;
   localparam int CNT_W     = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             toggle;
   logic             fall_evt;

   assign last       = CNT_W'(HALF_UNIT * int'(code_i) - 1);
   assign toggle     = tick_i && (cnt_q == last);
   assign rise_evt_o = toggle && !bclk_o;
   assign fall_evt   = toggle && bclk_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bclk_o <= 1'b0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else begin
         rise_o <= rise_evt_o;
         fall_o <= fall_evt;
         if (toggle) begin
            cnt_q  <= '0;
            bclk_o <= !bclk_o;
         end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));
   assert_rise_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> bclk_o);
   assert_fall_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> !bclk_o);
   assert_rise_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk_o) |-> rise_o);
   assert_fall_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bclk_o) |-> fall_o);
   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(bclk_o));

endmodule

// File: rtl/sfcg_framer.sv
module sfcg_framer #(
   parameter int FRAME_BITS = 128,
   parameter int SYNC_BITS  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rise_evt_i,
   output logic                          wrap_o,
   output logic [$clog2(FRAME_BITS)-1:0] idx_o,
   output logic                          frame_start_o,
   output logic                          sync_o
);

   localparam int IDX_W = $clog2(FRAME_BITS);

   if (FRAME_BITS < 2 || SYNC_BITS < 1 || SYNC_BITS >= FRAME_BITS) begin : g_bad_frame
      $error("sfcg_framer: need 1 <= SYNC_BITS < FRAME_BITS");
   end

   localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

   logic [IDX_W-1:0] idx_nxt;

   assign wrap_o = rise_evt_i && (idx_o == LAST);

   if (sfcg_pkg::is_pow2(FRAME_BITS)) begin : g_wrap_nat
      assign idx_nxt = idx_o + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_nxt = (idx_o == LAST) ? '0 : idx_o + 1'b1;
   end

   if (sfcg_pkg::is_pow2(SYNC_BITS)) begin : g_sync_msb
      localparam int SYNC_LSB = $clog2(SYNC_BITS);
      assign sync_o = ~|idx_o[IDX_W-1:SYNC_LSB];
   end else begin : g_sync_cmp
      assign sync_o = (idx_o < IDX_W'(SYNC_BITS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_o         <= LAST;
         frame_start_o <= 1'b0;
      end else begin
         frame_start_o <= wrap_o;
         if (rise_evt_i) begin
            idx_o <= idx_nxt;
         end
      end
   end

   assert_start_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |-> (idx_o == '0));
   assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_evt_i |=> $stable(idx_o));
   assert_sync_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_o) |-> frame_start_o);
   assert_sync_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_o) |-> (idx_o == IDX_W'(SYNC_BITS % FRAME_BITS)));

endmodule

// File: rtl/serial_frame_clkgen.sv
module serial_frame_clkgen #(
   parameter int NUM_SRC      = 3,
   parameter int CODE_W       = 3,
   parameter int CODE_MIN     = 1,
   parameter int CODE_MAX     = 6,
   parameter int STEP         = 4,
   parameter int FRAME_BITS   = 128,
   parameter int SYNC_BITS    = 16,
   parameter int RESTRICT_SRC = int'(sfcg_pkg::SRC_INT_HI),
   parameter int DEF_SRC      = int'(sfcg_pkg::SRC_INT_LO),
   parameter int DEF_CODE     = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SRC-1:0]            mclk_tick_i,
   input  logic                          cfg_load_i,
   input  logic [$clog2(NUM_SRC)-1:0]    cfg_src_i,
   input  logic [CODE_W-1:0]             cfg_code_i,
   input  logic                          cfg_codec_i,
   output logic                          bclk_o,
   output logic                          bclk_rise_o,
   output logic                          bclk_fall_o,
   output logic [$clog2(FRAME_BITS)-1:0] bit_idx_o,
   output logic                          frame_start_o,
   output logic                          sync_o,
   output logic                          cfg_err_o
);

   localparam int SRC_W = $clog2(NUM_SRC);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("serial_frame_clkgen: need at least two sources");
   end

   logic [SRC_W-1:0]  act_src;
   logic [CODE_W-1:0] act_code;
   logic              tick;
   logic              rise_evt;
   logic              wrap;

   sfcg_cfg #(
      .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CODE_W(CODE_W),
      .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .RESTRICT_SRC(RESTRICT_SRC),
      .DEF_SRC(DEF_SRC), .DEF_CODE(DEF_CODE)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .load_i(cfg_load_i), .src_i(cfg_src_i), .code_i(cfg_code_i),
      .codec_i(cfg_codec_i), .apply_i(wrap),
      .act_src_o(act_src), .act_code_o(act_code), .err_o(cfg_err_o)
   );

   sfcg_tick_sel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_sel (
      .ticks_i(mclk_tick_i), .sel_i(act_src), .tick_o(tick)
   );

   sfcg_divider #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .STEP(STEP)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .code_i(act_code),
      .rise_evt_o(rise_evt), .bclk_o(bclk_o),
      .rise_o(bclk_rise_o), .fall_o(bclk_fall_o)
   );

   sfcg_framer #(.FRAME_BITS(FRAME_BITS), .SYNC_BITS(SYNC_BITS)) u_frm (
      .clk(clk), .rst_n(rst_n), .rise_evt_i(rise_evt),
      .wrap_o(wrap), .idx_o(bit_idx_o),
      .frame_start_o(frame_start_o), .sync_o(sync_o)
   );

   assert_start_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |-> bclk_rise_o);

endmodule

// File: tb/sim_serial_frame_clkgen.sv
`timescale 1ns/1ps
module sim_serial_frame_clkgen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tick = '0;
   logic       ld = 1'b0;
   logic [1:0] src = '0;
   logic [2:0] code = '0;
   logic       codec = 1'b0;
   logic       bclk, rise, fall, fs, sync, err;
   logic [6:0] idx;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   serial_frame_clkgen u0 (
      .clk(clk), .rst_n(rst_n), .mclk_tick_i(tick), .cfg_load_i(ld),
      .cfg_src_i(src), .cfg_code_i(code), .cfg_codec_i(codec),
      .bclk_o(bclk), .bclk_rise_o(rise), .bclk_fall_o(fall),
      .bit_idx_o(idx), .frame_start_o(fs), .sync_o(sync), .cfg_err_o(err)
   );

   // reference state, built from the requirements
   int m_bclk = 0, m_rise = 0, m_fall = 0, m_idx = 127, m_fs = 0, m_err = 0;
   int m_cnt = 0, m_asrc = 0, m_acode = 1, m_psrc = 0, m_pcode = 1;

   function automatic bit legal(input int s, input int c, input int cd);
      return (c >= 1) && (c <= 6) && (s <= 2) && !(cd != 0 && s == 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_bclk = 0; m_rise = 0; m_fall = 0; m_idx = 127; m_fs = 0; m_err = 0;
         m_cnt = 0; m_asrc = 0; m_acode = 1; m_psrc = 0; m_pcode = 1;
      end else begin
         int ps, pc;
         ps = m_psrc; pc = m_pcode;
         m_rise = 0; m_fall = 0; m_fs = 0;
         if (tick[m_asrc]) begin
            if (m_cnt == 2 * m_acode - 1) begin
               m_cnt = 0;
               m_bclk = 1 - m_bclk;
               if (m_bclk == 1) begin
                  m_rise = 1;
                  m_idx = (m_idx + 1) % 128;
                  if (m_idx == 0) begin
                     m_fs = 1; m_asrc = ps; m_acode = pc;
                  end
               end else begin
                  m_fall = 1;
               end
            end else begin
               m_cnt++;
            end
         end
         if (ld) begin
            if (legal(int'(src), int'(code), int'(codec))) begin
               m_psrc = int'(src); m_pcode = int'(code); m_err = 0;
            end else begin
               m_err = 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   int hi_cnt = 0;
   int watch = 0;
   int watch_k = 0;

   task automatic compare_all();
      check(int'(bclk) == m_bclk, "R3 bclk level", int'(bclk), m_bclk);
      check(int'(rise) == m_rise, "R4 rise strobe", int'(rise), m_rise);
      check(int'(fall) == m_fall, "R4 fall strobe", int'(fall), m_fall);
      check(int'(idx) == m_idx, "R5 bit index", int'(idx), m_idx);
      check(int'(fs) == m_fs, "R6 frame start", int'(fs), m_fs);
      check(int'(sync) == int'(m_idx < 16), "R7 sync level", int'(sync), int'(m_idx < 16));
      check(int'(err) == m_err, "R8 error flag", int'(err), m_err);
   endtask

   // drive one cycle of inputs, then sample at the next falling edge
   task automatic step(input logic [2:0] t, input logic l, input logic [1:0] s,
                       input logic [2:0] c, input logic cd);
      if (bclk && t[m_asrc]) hi_cnt++;
      tick = t; ld = l; src = s; code = c; codec = cd;
      @(negedge clk);
      compare_all();
      if (watch == 1 && fs) watch = 2;
      if (fall) begin
         check(hi_cnt == 2 * m_acode, "R3 high phase length", hi_cnt, 2 * m_acode);
         if (watch == 2) begin
            check(hi_cnt == 2 * watch_k, "R10 first high phase after boundary", hi_cnt, 2 * watch_k);
            watch = 0;
         end
         hi_cnt = 0;
      end
   endtask

   function automatic logic [2:0] rnd_ticks();
      logic [2:0] t;
      for (int i = 0; i < 3; i++) t[i] = (($urandom % 10) < 7);
      return t;
   endfunction

   task automatic run_random(input int cycles);
      for (int i = 0; i < cycles; i++) step(rnd_ticks(), 1'b0, 2'd0, 3'd0, 1'b0);
   endtask

   task automatic load_once(input logic [1:0] s, input logic [2:0] c, input logic cd);
      step(rnd_ticks(), 1'b1, s, c, cd);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(bclk == 1'b0 && rise == 1'b0 && fall == 1'b0, "R1 clock idle", int'(bclk), 0);
      check(idx == 7'd127, "R1 bit index", int'(idx), 127);
      check(fs == 1'b0 && sync == 1'b0, "R1 frame outputs", int'(fs) + int'(sync), 0);
      check(err == 1'b0, "R1 error flag", int'(err), 0);

      run_random(3000);

      // R10: legal load mid-frame, external source, code 3
      load_once(2'd2, 3'd3, 1'b0);
      check(err == 1'b0, "R11 accepted load keeps flag clear", int'(err), 0);
      watch = 1; watch_k = 3;
      while (watch != 0) step(rnd_ticks(), 1'b0, 2'd0, 3'd0, 1'b0);

      // R2: only internal pulses while the external source is active
      begin
         logic       b0;
         logic [6:0] i0;
         b0 = bclk; i0 = idx;
         for (int i = 0; i < 200; i++) step(3'b011, 1'b0, 2'd0, 3'd0, 1'b0);
         check(bclk == b0, "R2 bclk frozen on other sources", int'(bclk), int'(b0));
         check(idx == i0, "R2 index frozen on other sources", int'(idx), int'(i0));
      end
      run_random(2000);

      // R8: illegal codes 0 and 7
      load_once(2'd0, 3'd0, 1'b0);
      check(err == 1'b1, "R8 code 0 refused", int'(err), 1);
      load_once(2'd1, 3'd4, 1'b0);
      check(err == 1'b0, "R11 legal load clears flag", int'(err), 0);
      load_once(2'd0, 3'd7, 1'b0);
      check(err == 1'b1, "R8 code 7 refused", int'(err), 1);
      run_random(20);
      check(err == 1'b1, "R11 flag holds without load", int'(err), 1);
      // R9: codec bound link may not use the higher-rate internal source
      load_once(2'd0, 3'd2, 1'b0);
      load_once(2'd1, 3'd2, 1'b1);
      check(err == 1'b1, "R9 codec restriction refused", int'(err), 1);
      // R2: source code 3 refused
      load_once(2'd0, 3'd2, 1'b1);
      check(err == 1'b0, "R9 codec with lower-rate source accepted", int'(err), 0);
      load_once(2'd3, 3'd2, 1'b0);
      check(err == 1'b1, "R2 source 3 refused", int'(err), 1);
      run_random(12000);

      // random configuration traffic, all codes including illegal ones
      for (int i = 0; i < 110000; i++) begin
         if (($urandom % 400) == 0)
            step(rnd_ticks(), 1'b1, 2'($urandom % 4), 3'($urandom % 8), 1'($urandom % 2));
         else
            step(rnd_ticks(), 1'b0, 2'd0, 3'd0, 1'b0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule